// File: doc/BRIEF.md
# Memory Address Disposition Decoder

This block sits beside a host bus and classifies every memory transaction. For each request it looks at the 32-bit address, the direction (outbound from the processor or inbound from I/O), read or write, the locked flag and the access size in bytes. It then produces a single routing code that tells the surrounding logic where the cycle goes: DRAM, PCI, the second expander port, the configuration unit, an interrupt transaction, a drop with a no-data response, unclaimed, or error.

The legacy area below 1 MB is split into windows. Each window is steered by a 2-bit attribute field that gives reads, writes and locked reads their own rules. A video-memory enable controls the 0xA0000 window. A programmable top-of-DRAM boundary splits memory above 1 MB between DRAM and PCI. A small register port writes these control fields. The window near the top of the 4 GB space is decoded by fixed ranges, and that decode depends on direction, size and lock.

The routing code is registered. It appears one clock after the request strobe, together with a valid flag.

Top module: `adr_route_top`

## Requirements
- R1: After reset `rsp_valid` is 0 and `rsp_route` is 6 (unclaimed). Every attribute field resets to 00, the video enable resets to 0, the top-of-DRAM boundary resets to 0x0010_0000 and the expander-absent flag resets to 0. Route codes: 0 DRAM, 1 PCI, 2 expander port, 3 configuration unit, 4 interrupt, 5 drop with no-data response, 6 unclaimed, 7 error.
- R2: `rsp_valid` equals `req_valid` delayed by one clock, and `rsp_route` carries the decode of the request from that earlier cycle. With no request, `rsp_route` holds its value.
- R3: Addresses 0x0 to 0x7_FFFF route to DRAM in both directions.
- R4: Attribute fields are 2 bits wide:
  - 11 sends reads and writes to DRAM.
  - 00 sends both to PCI.
  - 01 sends unlocked reads to DRAM, and sends locked reads and all writes to PCI.
  - 10 sends writes to DRAM and reads to PCI.

  Field 12 covers 0x8_0000 to 0x9_FFFF. Field 13 covers 0xF_0000 to 0xF_FFFF. Fields 0 to 11 cover 0xC_0000 to 0xE_FFFF in 16 KB steps, field k starting at 0xC_0000 + k*0x4000.
- R5: In the attribute-controlled windows and the video window, an inbound access that would have gone to PCI is reported as unclaimed instead.
- R6: 0xA_0000 to 0xB_FFFF routes to DRAM when the video enable is 0. When it is 1, outbound accesses go to PCI and inbound accesses are unclaimed.
- R7: From 0x10_0000 up to but not including the boundary, accesses route to DRAM. From the boundary up to 0xFDFF_FFFF, accesses route to PCI. Both directions behave the same.
- R8: 0xFE20_0000 to 0xFE3F_FFFF routes to the expander port when the expander-absent flag is 0, and to PCI when it is 1. 0xFE00_0000 to 0xFE1F_FFFF and 0xFE40_0000 to 0xFE5F_FFFF are unclaimed.
- R9: In 0xFE60_0000 to 0xFEBF_FFFF, any locked access gives error. An unlocked access of 8 bytes or fewer goes to the configuration unit, and a larger one goes to PCI.
- R10: In 0xFED0_0000 to 0xFEDF_FFFF, outbound reads go to PCI, outbound writes are dropped, and inbound accesses go to DRAM.
- R11: In 0xFEE0_0000 to 0xFEEF_FFFF, inbound writes become interrupts, reads in either direction go to PCI, and outbound writes are dropped.
- R12: Every other address, including 0xFEC0_0000 to 0xFECF_FFFF and 0xFEF0_0000 upward, is unclaimed.
- R13: A pulse on `cfg_we` stores `cfg_data` into the field chosen by `cfg_idx`:
  - indices 0 to 13 load attribute field k from bits 1:0;
  - index 14 loads the video enable from bit 0;
  - index 15 loads the top-of-DRAM boundary from bits 31:0;
  - index 16 loads the expander-absent flag from bit 0.

  The write applies to requests presented from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Byte address of the transaction |
| req_inbound | input | 1 | 1 = inbound from I/O, 0 = outbound from processor |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lock | input | 1 | Locked cycle |
| req_size | input | 7 | Access size in bytes |
| cfg_we | input | 1 | Control field write strobe |
| cfg_idx | input | 5 | Control field select |
| cfg_data | input | 32 | Control field write data |
| rsp_valid | output | 1 | Routing code valid |
| rsp_route | output | 3 | Registered routing code |

## Verification
On every cycle the assertions check the one-cycle strobe timing, the hold of the route between requests, the fixed DRAM low window and the error code for locked configuration accesses. They also check that an inbound request never yields a drop and an outbound request never yields an interrupt. The attribute semantics, the video and boundary settings, the size threshold and the expander-absent steering all depend on programmed state. Only the bench scenarios show those: they reprogram the fields and compare each registered code against an independent model.

// File: rtl/adr_pkg.sv
package adr_pkg;
  localparam int ADDR_W = 32;

  typedef enum logic [2:0] {
    RT_DRAM = 3'd0,
    RT_PCI  = 3'd1,
    RT_EXP  = 3'd2,
    RT_CFG  = 3'd3,
    RT_INTR = 3'd4,
    RT_DROP = 3'd5,
    RT_UNCL = 3'd6,
    RT_ERR  = 3'd7
  } route_e;

  typedef enum logic [3:0] {
    RG_LOW, RG_ATTR, RG_VGA, RG_DRAMHI, RG_PCIHI,
    RG_EXP, RG_CFG, RG_FED, RG_FEE, RG_NONE
  } region_e;

  typedef logic [1:0] attr_t;
  localparam attr_t AT_PCI     = 2'b00;
  localparam attr_t AT_RD_DRAM = 2'b01;
  localparam attr_t AT_WR_DRAM = 2'b10;
  localparam attr_t AT_DRAM    = 2'b11;

  // window edges (inclusive low, exclusive high)
  localparam logic [31:0] LOW_END   = 32'h0008_0000;
  localparam logic [31:0] SEG_A_END = 32'h000A_0000;
  localparam logic [31:0] VGA_END   = 32'h000C_0000;
  localparam logic [31:0] BLK_END   = 32'h000F_0000;
  localparam logic [31:0] MEG       = 32'h0010_0000;
  localparam logic [31:0] HOLE_LO   = 32'hFE00_0000;
  localparam logic [31:0] EXP_LO    = 32'hFE20_0000;
  localparam logic [31:0] EXP_HI    = 32'hFE40_0000;
  localparam logic [31:0] CFG_LO    = 32'hFE60_0000;
  localparam logic [31:0] CFG_HI    = 32'hFEC0_0000;
  localparam logic [31:0] FED_LO    = 32'hFED0_0000;
  localparam logic [31:0] FEE_LO    = 32'hFEE0_0000;
  localparam logic [31:0] FEE_HI    = 32'hFEF0_0000;

  function automatic logic in_win(logic [31:0] a, logic [31:0] lo, logic [31:0] hi);
    return (a >= lo) && (a < hi);
  endfunction

  // does an attribute field steer this access to DRAM
  function automatic logic attr_to_dram(attr_t a, logic wr, logic lk);
    case (a)
      AT_DRAM:    return 1'b1;
      AT_RD_DRAM: return !wr && !lk;
      AT_WR_DRAM: return wr;
      default:    return 1'b0;
    endcase
  endfunction

  // legacy windows: PCI-bound inbound traffic is unclaimed
  function automatic route_e legacy_route(logic to_dram, logic inb);
    if (to_dram) return RT_DRAM;
    else if (inb) return RT_UNCL;
    else return RT_PCI;
  endfunction
endpackage

// File: rtl/adr_cfg_regs.sv
module adr_cfg_regs
  import adr_pkg::*;
#(
  parameter int NUM_ATTR = 14,
  parameter int IDX_W    = 5,
  parameter logic [31:0] TOP_RESET = 32'h0010_0000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [IDX_W-1:0]         cfg_idx,
  input  logic [31:0]              cfg_data,
  output attr_t [NUM_ATTR-1:0]     attr_q,
  output logic                     vga_en_q,
  output logic [31:0]              dram_top_q,
  output logic                     exp_absent_q
);
  localparam int IDX_VGA = NUM_ATTR;
  localparam int IDX_TOP = NUM_ATTR + 1;
  localparam int IDX_EXP = NUM_ATTR + 2;

  for (genvar i = 0; i < NUM_ATTR; i++) begin : g_attr
    always_ff @(posedge clk) begin
      if (!rst_n) attr_q[i] <= AT_PCI;
      else if (cfg_we && cfg_idx == IDX_W'(i)) attr_q[i] <= cfg_data[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vga_en_q     <= 1'b0;
      dram_top_q   <= TOP_RESET;
      exp_absent_q <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_idx == IDX_W'(IDX_VGA)) vga_en_q     <= cfg_data[0];
      if (cfg_idx == IDX_W'(IDX_TOP)) dram_top_q   <= cfg_data;
      if (cfg_idx == IDX_W'(IDX_EXP)) exp_absent_q <= cfg_data[0];
    end
  end
endmodule

// File: rtl/adr_region_map.sv
module adr_region_map
  import adr_pkg::*;
#(
  parameter int NUM_BLOCKS  = 12,
  parameter int BLOCK_SHIFT = 14,
  parameter int AIDX_W      = 4
) (
  input  logic [31:0]       addr,
  input  logic [31:0]       dram_top,
  output region_e           region,
  output logic [AIDX_W-1:0] attr_idx
);
  localparam int IDX_SEG_A = NUM_BLOCKS;
  localparam int IDX_SEG_F = NUM_BLOCKS + 1;

  logic [31:0] blk_off;
  assign blk_off = (addr - VGA_END) >> BLOCK_SHIFT;

  always_comb begin
    region   = RG_NONE;
    attr_idx = '0;
    if (addr < LOW_END) region = RG_LOW;
    else if (addr < SEG_A_END) begin
      region   = RG_ATTR;
      attr_idx = AIDX_W'(IDX_SEG_A);
    end else if (addr < VGA_END) region = RG_VGA;
    else if (addr < BLK_END) begin
      region   = RG_ATTR;
      attr_idx = blk_off[AIDX_W-1:0];
    end else if (addr < MEG) begin
      region   = RG_ATTR;
      attr_idx = AIDX_W'(IDX_SEG_F);
    end else if (addr < HOLE_LO) region = (addr < dram_top) ? RG_DRAMHI : RG_PCIHI;
    else if (in_win(addr, EXP_LO, EXP_HI)) region = RG_EXP;
    else if (in_win(addr, CFG_LO, CFG_HI)) region = RG_CFG;
    else if (in_win(addr, FED_LO, FEE_LO)) region = RG_FED;
    else if (in_win(addr, FEE_LO, FEE_HI)) region = RG_FEE;
  end
endmodule

// File: rtl/adr_route_pick.sv
module adr_route_pick
  import adr_pkg::*;
#(
  parameter int SIZE_W        = 7,
  parameter int CFG_MAX_BYTES = 8
) (
  input  region_e           region,
  input  attr_t             attr,
  input  logic              inb,
  input  logic              wr,
  input  logic              lk,
  input  logic [SIZE_W-1:0] size,
  input  logic              vga_en,
  input  logic              exp_absent,
  output route_e            route
);
  logic small_acc;
  assign small_acc = size <= SIZE_W'(CFG_MAX_BYTES);

  always_comb begin
    case (region)
      RG_LOW:    route = RT_DRAM;
      RG_ATTR:   route = legacy_route(attr_to_dram(attr, wr, lk), inb);
      RG_VGA:    route = legacy_route(!vga_en, inb);
      RG_DRAMHI: route = RT_DRAM;
      RG_PCIHI:  route = RT_PCI;
      RG_EXP:    route = exp_absent ? RT_PCI : RT_EXP;
      RG_CFG:    route = lk ? RT_ERR : (small_acc ? RT_CFG : RT_PCI);
      RG_FED:    route = inb ? RT_DRAM : (wr ? RT_DROP : RT_PCI);
      RG_FEE:    route = !wr ? RT_PCI : (inb ? RT_INTR : RT_DROP);
      default:   route = RT_UNCL;
    endcase
  end
endmodule

// File: rtl/adr_route_top.sv
module adr_route_top
  import adr_pkg::*;
#(
  parameter int SIZE_W        = 7,
  parameter int IDX_W         = 5,
  parameter int NUM_BLOCKS    = 12,
  parameter int CFG_MAX_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  input  logic              req_inbound,
  input  logic              req_write,
  input  logic              req_lock,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [31:0]       cfg_data,
  output logic              rsp_valid,
  output logic [2:0]        rsp_route
);
  localparam int NUM_ATTR = NUM_BLOCKS + 2;
  localparam int AIDX_W   = $clog2(NUM_ATTR);

  attr_t [NUM_ATTR-1:0] attr_q;
  logic                 vga_en_q;
  logic [31:0]          dram_top_q;
  logic                 exp_absent_q;

  region_e              dec_region;
  logic [AIDX_W-1:0]    dec_attr_idx;
  attr_t                dec_attr;
  route_e               dec_route;

  adr_cfg_regs #(.NUM_ATTR(NUM_ATTR), .IDX_W(IDX_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_idx      (cfg_idx),
    .cfg_data     (cfg_data),
    .attr_q       (attr_q),
    .vga_en_q     (vga_en_q),
    .dram_top_q   (dram_top_q),
    .exp_absent_q (exp_absent_q)
  );

  adr_region_map #(.NUM_BLOCKS(NUM_BLOCKS), .AIDX_W(AIDX_W)) u_map (
    .addr     (req_addr),
    .dram_top (dram_top_q),
    .region   (dec_region),
    .attr_idx (dec_attr_idx)
  );

  assign dec_attr = (int'(dec_attr_idx) < NUM_ATTR) ? attr_q[dec_attr_idx] : AT_PCI;

  adr_route_pick #(.SIZE_W(SIZE_W), .CFG_MAX_BYTES(CFG_MAX_BYTES)) u_pick (
    .region     (dec_region),
    .attr       (dec_attr),
    .inb        (req_inbound),
    .wr         (req_write),
    .lk         (req_lock),
    .size       (req_size),
    .vga_en     (vga_en_q),
    .exp_absent (exp_absent_q),
    .route      (dec_route)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_route <= RT_UNCL;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_route <= dec_route;
    end
  end
endmodule

// File: rtl/adr_route_chk.sv
module adr_route_chk
  import adr_pkg::*;
#(
  parameter int SIZE_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [31:0]       req_addr,
  input logic              req_inbound,
  input logic              req_write,
  input logic              req_lock,
  input logic [SIZE_W-1:0] req_size,
  input logic              rsp_valid,
  input logic [2:0]        rsp_route
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  logic cfg_hit;
  assign cfg_hit = in_win(req_addr, CFG_LO, CFG_HI);

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> rsp_valid == $past(req_valid)); // R2
  AST_ROUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !req_valid) |=> $stable(rsp_route)); // R2
  AST_LOW_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr < LOW_END) |=> rsp_route == RT_DRAM); // R3
  AST_LOCK_CFG_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_lock && cfg_hit) |=> rsp_route == RT_ERR); // R9
  AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !(req_lock && cfg_hit)) |=> rsp_route != RT_ERR); // R9
  AST_INBOUND_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_inbound) |=> rsp_route != RT_DROP); // R10
  AST_OUTBOUND_NO_INTR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_inbound) |=> rsp_route != RT_INTR); // R11
  AST_TOP_UNCL: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr >= FEE_HI) |=> rsp_route == RT_UNCL); // R12

  logic unused_ok;
  assign unused_ok = ^{req_write, req_size};
endmodule

bind adr_route_top adr_route_chk #(.SIZE_W(SIZE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .req_inbound (req_inbound),
  .req_write   (req_write),
  .req_lock    (req_lock),
  .req_size    (req_size),
  .rsp_valid   (rsp_valid),
  .rsp_route   (rsp_route)
);

// File: tb/sim_adr_route_top.sv
`timescale 1ns/1ps
module sim_adr_route_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_inbound = 1'b0, req_write = 1'b0, req_lock = 1'b0;
  logic [6:0]  req_size = 7'd4;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic        rsp_valid;
  logic [2:0]  rsp_route;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench copy of the programmed fields
  int unsigned m_attr [14];
  bit          m_vga, m_exp;
  logic [31:0] m_top;

  always #2 clk = ~clk;

  adr_route_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_inbound(req_inbound), .req_write(req_write), .req_lock(req_lock),
    .req_size(req_size), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .rsp_valid(rsp_valid), .rsp_route(rsp_route)
  );

  function automatic int legacy(int unsigned a, bit inb, bit wr, bit lk);
    bit d;
    d = (a == 3) || (a == 1 && !wr && !lk) || (a == 2 && wr);
    if (d) return 0;
    return inb ? 6 : 1;
  endfunction

  function automatic int expect_route(logic [31:0] a, bit inb, bit wr, bit lk, int sz);
    if (a < 32'h80000) return 0;
    if (a < 32'hA0000) return legacy(m_attr[12], inb, wr, lk);
    if (a < 32'hC0000) return m_vga ? (inb ? 6 : 1) : 0;
    if (a < 32'hF0000) return legacy(m_attr[(a - 32'hC0000) / 32'h4000], inb, wr, lk);
    if (a < 32'h100000) return legacy(m_attr[13], inb, wr, lk);
    if (a < 32'hFE000000) return (a < m_top) ? 0 : 1;
    if (a < 32'hFE200000) return 6;
    if (a < 32'hFE400000) return m_exp ? 1 : 2;
    if (a < 32'hFE600000) return 6;
    if (a < 32'hFEC00000) return lk ? 7 : ((sz <= 8) ? 3 : 1);
    if (a < 32'hFED00000) return 6;
    if (a < 32'hFEE00000) return inb ? 0 : (wr ? 5 : 1);
    if (a < 32'hFEF00000) return wr ? (inb ? 4 : 5) : 1;
    return 6;
  endfunction

  function automatic string tag_of(logic [31:0] a);
    if (a < 32'h80000) return "R3";
    if (a >= 32'hA0000 && a < 32'hC0000) return "R6";
    if (a < 32'h100000) return "R4";
    if (a < 32'hFE000000) return "R7";
    if (a >= 32'hFE200000 && a < 32'hFE400000) return "R8";
    if (a >= 32'hFE600000 && a < 32'hFEC00000) return "R9";
    if (a >= 32'hFED00000 && a < 32'hFEE00000) return "R10";
    if (a >= 32'hFEE00000 && a < 32'hFEF00000) return "R11";
    return "R12";
  endfunction

  task automatic check(bit ok, string tag, int act, int exp_v, logic [31:0] a);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s addr=%h actual=%0d expected=%0d", tag, a, act, exp_v);
    end
  endtask

  task automatic cfg_write(int idx, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (idx < 14) m_attr[idx] = d[1:0];
    else if (idx == 14) m_vga = d[0];
    else if (idx == 15) m_top = d;
    else if (idx == 16) m_exp = d[0];
  endtask

  task automatic send(logic [31:0] a, bit inb, bit wr, bit lk, int sz, string tag);
    int e;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_inbound = inb; req_write = wr;
    req_lock = lk; req_size = 7'(sz);
    e = expect_route(a, inb, wr, lk, sz);
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid === 1'b1, "R2", int'(rsp_valid), 1, a);
    check(rsp_route === 3'(e), tag, int'(rsp_route), e, a);
  endtask

  function automatic logic [31:0] pick_addr();
    int k;
    k = int'($urandom % 10);
    case (k)
      0: return $urandom % 32'h100000;
      1: return 32'h80000 + ($urandom % 32'h20000);
      2: return 32'hC0000 + ($urandom % 32'h30000);
      3: return m_top - 32'd8 + ($urandom % 16);
      4: return 32'hFE000000 + ($urandom % 32'h600000);
      5: return 32'hFE600000 + ($urandom % 32'h600000);
      6: return 32'hFEC00000 + ($urandom % 32'h300000);
      7: return 32'hFEF00000 + ($urandom % 32'h100000);
      8: return 32'hF0000 + ($urandom % 32'h20000);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    int e;
    void'($urandom(32'd4242));
    foreach (m_attr[i]) m_attr[i] = 0;
    m_vga = 0; m_exp = 0; m_top = 32'h0010_0000;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(rsp_valid === 1'b0, "R1", int'(rsp_valid), 0, 0);
    check(rsp_route === 3'd6, "R1", int'(rsp_route), 6, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid === 1'b0, "R2", int'(rsp_valid), 0, 0);
    // R1 reset fields: attr 00 -> PCI, vga off, top 1 MB, expander present
    send(32'h0009_0000, 0, 0, 0, 4, "R1");
    send(32'h000A_1000, 0, 0, 0, 4, "R1");
    send(32'h0010_0000, 0, 0, 0, 4, "R1");
    send(32'h0020_0000, 1, 1, 0, 4, "R1");
    send(32'hFE30_0000, 0, 0, 0, 4, "R1");
    // R3 low window
    send(32'h0000_0000, 1, 1, 1, 4, "R3");
    send(32'h0007_FFFF, 0, 0, 0, 4, "R3");
    // R4 / R5 attribute semantics on field 12
    cfg_write(12, 32'h1);
    send(32'h0008_0000, 0, 0, 0, 4, "R4");
    send(32'h0008_0000, 0, 0, 1, 4, "R4");
    send(32'h0008_0000, 0, 1, 0, 4, "R4");
    send(32'h0009_FFFF, 1, 0, 1, 4, "R5");
    cfg_write(12, 32'h2);
    send(32'h0008_0000, 0, 1, 0, 4, "R4");
    send(32'h0008_0000, 1, 0, 0, 4, "R5");
    // R4 block field mapping: field 5 at 0xD4000
    cfg_write(5, 32'h3);
    send(32'h000D_4000, 1, 0, 0, 4, "R4");
    send(32'h000D_3FFF, 1, 0, 0, 4, "R5");
    send(32'h000D_8000, 0, 1, 0, 4, "R4");
    // R13 write takes effect next cycle: request in same cycle uses old field
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 5'd13; cfg_data = 32'h3;
    req_valid = 1'b1; req_addr = 32'h000F_8000; req_inbound = 0; req_write = 0; req_lock = 0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0; m_attr[13] = 3;
    check(rsp_route === 3'd1, "R13", int'(rsp_route), 1, 32'hF8000);
    send(32'h000F_8000, 0, 0, 0, 4, "R13");
    // R2 hold with no request
    @(negedge clk);
    @(negedge clk);
    check(rsp_valid === 1'b0, "R2", int'(rsp_valid), 0, 0);
    check(rsp_route === 3'd0, "R2", int'(rsp_route), 0, 0);
    // R6 video window
    cfg_write(14, 32'h1);
    send(32'h000B_0000, 0, 1, 0, 4, "R6");
    send(32'h000B_0000, 1, 1, 0, 4, "R6");
    // R7 boundary
    cfg_write(15, 32'h2000_0000);
    send(32'h1FFF_FFFF, 1, 0, 0, 4, "R7");
    send(32'h2000_0000, 0, 0, 0, 4, "R7");
    send(32'hFDFF_FFFF, 1, 1, 0, 4, "R7");
    send(32'hFE00_0000, 0, 0, 0, 4, "R8");
    send(32'hFE5F_FFFF, 0, 0, 0, 4, "R8");
    // R8 expander absent
    send(32'hFE20_0000, 1, 1, 0, 4, "R8");
    cfg_write(16, 32'h1);
    send(32'hFE3F_FFFF, 0, 0, 0, 4, "R8");
    // R9 config range size and lock
    send(32'hFE60_0000, 0, 0, 0, 8, "R9");
    send(32'hFE60_0000, 0, 0, 0, 9, "R9");
    send(32'hFEBF_FFF8, 1, 1, 1, 4, "R9");
    // R10, R11
    send(32'hFED0_0000, 0, 0, 0, 4, "R10");
    send(32'hFED0_0000, 0, 1, 0, 4, "R10");
    send(32'hFEDF_FFFF, 1, 1, 0, 4, "R10");
    send(32'hFEE0_0000, 1, 1, 0, 4, "R11");
    send(32'hFEE0_0000, 0, 1, 0, 4, "R11");
    send(32'hFEEF_FFFF, 1, 0, 0, 4, "R11");
    // R12 leftovers
    send(32'hFEC0_0000, 0, 0, 0, 4, "R12");
    send(32'hFFFF_FFFF, 1, 1, 0, 4, "R12");
    // random mix with occasional reprogramming
    for (int n = 0; n < 600; n++) begin
      if ($urandom % 12 == 0) begin
        int idx;
        idx = int'($urandom % 17);
        if (idx == 15) cfg_write(15, 32'h0010_0000 + ($urandom % 32'h8000_0000));
        else cfg_write(idx, $urandom);
      end
      a = pick_addr();
      send(a, 1'($urandom), 1'($urandom), 1'($urandom % 4 == 0),
           int'($urandom % 20), tag_of(a));
    end
    // back-to-back requests: R2 pipeline
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h100; req_inbound = 0; req_write = 0; req_lock = 0;
    @(negedge clk);
    check(rsp_route === 3'd0, "R2", int'(rsp_route), 0, 32'h100);
    req_addr = 32'hFFF0_0000;
    @(negedge clk);
    req_valid = 1'b0;
    e = 6;
    check(rsp_route === 3'(e), "R2", int'(rsp_route), e, 32'hFFF00000);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule